// File: doc/BRIEF.md
# Fixed-Width Radix-4 Multiplier with Truncation Bias

This block multiplies two signed N-bit operands and returns only an N-bit result that approximates the upper half of the full 2N-bit product. Radix-4 recoding gives N/2 partial-product rows. The sign of each row is handled by inverting its top bit and folding all the sign corrections into one constant. The columns below weight 2^N are not summed. The one exception is column N-1, the highest discarded column. Its N/2 bits feed a small estimator that predicts the carry that truncation loses, and that estimate is added at weight 2^N. The parameter `COMPENSATE` set to 0 removes the estimator, which gives plain direct truncation with the same upper-column constants so that the two variants can be compared.

Operands enter on a valid/ready stream and results leave on a second valid/ready stream through a single output register. An operand pair transfers on a rising edge where `in_valid` and `in_ready` are both high. Its result is presented with `out_valid` high from the next cycle onward. It stays unchanged for as long as `out_ready` is low. `in_ready` is low exactly while a result is held and `out_ready` is low. With `out_ready` held high, one pair is accepted in every cycle.

Top module: `fwb_mul`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `out_valid` is 0 and `in_ready` is 1.
- R2: Row i (0 <= i < N/2) takes the bit triplet (b[2i+1], b[2i], b[2i-1]), where b[-1] = 0. Its digit is d = b[2i] + b[2i-1] - 2*b[2i+1]. Its flag neg is b[2i+1] AND NOT(b[2i] AND b[2i-1]). The row bits r[0..N] are the (N+1)-bit two's-complement value d*A - neg, and row bit j sits at column 2i+j.
- R3: With COMPENSATE=0, `out_prod` is bits [2N-1:N] of K. K is the sum of all row bits at columns >= N, with bit r[N] of each row inverted, plus the constant -2^N*(4^(N/2)-1)/3. The error A*B - signed(out_prod)*2^N then always lies in [0, (N/2+1)*2^N).
- R4: With COMPENSATE=1, `out_prod` is bits [2N-1:N] of K + c*2^N, where c = E + F - 1. E is the count of ones among the N/2 row bits in column N-1 (row i, bit N-1-2i), and F = 1 when all of them are one, else 0.
- R5: When every column N-1 bit is one, the added estimate is exactly N/2.
- R6: For a multiplier operand of zero, the result is all ones with compensation and zero without it.
- R7: Over all operand pairs, the mean absolute error of the compensated result is smaller than that of direct truncation.
- R8: An operand pair accepted on an edge yields `out_valid` = 1 after that edge, and results leave in acceptance order.
- R9: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0, and `out_valid` and `out_prod` keep their values on the next edge.
- R10: With `out_ready` high, `in_ready` is high, so one pair is accepted per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block can take an operand pair |
| in_a | input | N | Multiplicand, two's complement |
| in_b | input | N | Multiplier, two's complement |
| out_valid | output | 1 | Result held on `out_prod` |
| out_ready | input | 1 | Consumer takes the result |
| out_prod | output | N | Upper-half product estimate |

## Verification
The product logic has no state between operands, so a wrong recoding select, a misplaced row bit or a wrong estimator count appears in `out_prod` in the first cycle after the offending pair is accepted. The bench compares every result against an independent column-by-column model. A fault in the output register or handshake shows as a lost, duplicated or reordered result, or as a result that changes during a stall. The scoreboard catches these on the next presented result, and per-cycle checks of `in_ready` under stall and free-flow catch them at once. The error-statistics sweep catches estimator faults that stay within range but are biased, because they raise the mean error.

// File: rtl/fwb_pkg.sv
package fwb_pkg;

  // Selection produced by one radix-4 recoder
  typedef struct packed {
    logic neg;  // invert row and add one at its LSB
    logic dbl;  // magnitude two
    logic sgl;  // magnitude one
  } bsel_t;

  // Sum over rows of 4^i, i = 0 .. n/2-1, equals (2^n - 1) / 3 for even n
  function automatic int unsigned row_weight_sum(input int unsigned n);
    return ((32'd1 << n) - 32'd1) / 32'd3;
  endfunction

endpackage

// File: rtl/fwb_booth_digit.sv
module fwb_booth_digit
  import fwb_pkg::*;
(
  input  logic [2:0] trip,
  output bsel_t      sel
);
  always_comb begin
    sel.sgl = trip[1] ^ trip[0];
    sel.dbl = (trip == 3'b011) | (trip == 3'b100);
    sel.neg = trip[2] & ~(trip[1] & trip[0]);
  end
endmodule

// File: rtl/fwb_pp_row.sv
module fwb_pp_row
  import fwb_pkg::*;
#(
  parameter int N   = 8,
  parameter int ROW = 0
) (
  input  logic [N-1:N-2-2*ROW] a_hi,
  input  bsel_t                sel,
  output logic [N-1:0]         upper,
  output logic                 col_bit
);
  // lowest row bit that is still needed: the one landing in column N-1
  localparam int LO = N - 1 - 2 * ROW;

  logic [N:LO-1] a_ext;
  logic [N:LO]   rb;

  assign a_ext = {a_hi[N-1], a_hi};

  for (genvar j = LO; j <= N; j++) begin : g_bit
    assign rb[j] = sel.neg ^ ((sel.sgl & a_ext[j]) | (sel.dbl & a_ext[j-1]));
  end

  assign col_bit = rb[LO];

  // upper[k] is the row's bit in column N+k
  for (genvar k = 0; k < N; k++) begin : g_up
    if (k < 2 * ROW) begin : g_body
      assign upper[k] = rb[LO + 1 + k];
    end else if (k == 2 * ROW) begin : g_sign
      assign upper[k] = ~rb[N];
    end else begin : g_pad
      assign upper[k] = 1'b0;
    end
  end
endmodule

// File: rtl/fwb_comp_bias.sv
module fwb_comp_bias #(
  parameter int N = 8,
  parameter int H = N / 2
) (
  input  logic [H-1:0] col_bits,
  output logic [N-1:0] bias
);
  localparam int CW = $clog2(H + 1);

  logic [CW-1:0] ones;
  logic          full;

  always_comb begin
    ones = '0;
    for (int i = 0; i < H; i++) begin
      ones = ones + CW'(col_bits[i]);
    end
  end

  assign full = &col_bits;
  assign bias = N'(ones) + N'(full) - N'(1);
endmodule

// File: rtl/fwb_core.sv
module fwb_core
  import fwb_pkg::*;
#(
  parameter int N          = 8,
  parameter bit COMPENSATE = 1'b1
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  output logic [N-1:0] prod
);
  localparam int H = N / 2;
  // upper half of the folded sign-correction constant
  localparam logic [N-1:0] SG_HI = ~N'(row_weight_sum(N)) + N'(1);

  logic [N:0]   b_ext;
  bsel_t        sel   [H];
  logic [N-1:0] upper [H];
  logic [H-1:0] col_bits;
  logic [N-1:0] bias;
  logic [N-1:0] acc;

  assign b_ext = {b, 1'b0};

  for (genvar i = 0; i < H; i++) begin : g_row
    fwb_booth_digit u_dig (
      .trip (b_ext[2*i+2:2*i]),
      .sel  (sel[i])
    );
    fwb_pp_row #(.N(N), .ROW(i)) u_row (
      .a_hi    (a[N-1:N-2-2*i]),
      .sel     (sel[i]),
      .upper   (upper[i]),
      .col_bit (col_bits[i])
    );
  end

  if (COMPENSATE) begin : g_comp
    fwb_comp_bias #(.N(N), .H(H)) u_bias (
      .col_bits (col_bits),
      .bias     (bias)
    );
  end else begin : g_trunc
    assign bias = '0;
  end

  always_comb begin
    acc = SG_HI + bias;
    for (int i = 0; i < H; i++) begin
      acc = acc + upper[i];
    end
  end

  assign prod = acc;
endmodule

// File: rtl/fwb_mul.sv
module fwb_mul #(
  parameter int N          = 8,
  parameter bit COMPENSATE = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [N-1:0] in_a,
  input  logic [N-1:0] in_b,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [N-1:0] out_prod
);
  logic [N-1:0] prod_c;
  logic [N-1:0] prod_q;
  logic         vld_q;
  logic         take;

  fwb_core #(.N(N), .COMPENSATE(COMPENSATE)) u_core (
    .a    (in_a),
    .b    (in_b),
    .prod (prod_c)
  );

  assign in_ready = ~vld_q | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
    end else if (in_ready) begin
      vld_q <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      prod_q <= prod_c;
    end
  end

  assign out_valid = vld_q;
  assign out_prod  = prod_q;
endmodule

// File: rtl/fwb_mul_chk.sv
module fwb_mul_chk #(
  parameter int N          = 8,
  parameter bit COMPENSATE = 1'b1
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         in_ready,
  input logic [N-1:0] in_b,
  input logic         out_valid,
  input logic         out_ready,
  input logic [N-1:0] out_prod
);
  localparam logic [N-1:0] ZERO_RES = COMPENSATE ? {N{1'b1}} : {N{1'b0}};

  // R1
  out_idle_after_rst_chk: assert property (@(posedge clk) rst |=> !out_valid);

  // R8
  accept_gives_valid_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);

  // R9
  stall_blocks_input_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);

  // R9
  stall_holds_result_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_prod));

  // R10
  free_flow_ready_chk: assert property (@(posedge clk) disable iff (rst)
    out_ready |-> in_ready);

  // R6
  zero_multiplier_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && in_b == '0 |=> out_prod == ZERO_RES);

  // R8
  drained_goes_idle_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && !in_valid |=> !out_valid);
endmodule

bind fwb_mul fwb_mul_chk #(.N(N), .COMPENSATE(COMPENSATE)) u_fwb_mul_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_b      (in_b),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_prod  (out_prod)
);

// File: tb/test_fwb_mul.sv
module test_fwb_mul;
  localparam int N = 8;
  localparam int H = N / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic         in_valid = 1'b0;
  logic         out_ready = 1'b0;
  logic [N-1:0] in_a = '0;
  logic [N-1:0] in_b = '0;
  logic         rdy_c, rdy_t, vld_c, vld_t;
  logic [N-1:0] prod_c, prod_t;

  fwb_mul #(.N(N), .COMPENSATE(1'b1)) i_fwb_mul (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy_c),
    .in_a(in_a), .in_b(in_b), .out_valid(vld_c), .out_ready(out_ready),
    .out_prod(prod_c)
  );

  fwb_mul #(.N(N), .COMPENSATE(1'b0)) i_fwb_mul_trunc (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy_t),
    .in_a(in_a), .in_b(in_b), .out_valid(vld_t), .out_ready(out_ready),
    .out_prod(prod_t)
  );

  logic [N-1:0] qa[$];
  logic [N-1:0] qb[$];
  int     n_tests = 0;
  int     n_fail = 0;
  int     full_hits = 0;
  bit     done = 1'b0;
  bit     stats_on = 1'b0;
  bit     pushed_last = 1'b0;
  bit     stalled_last = 1'b0;
  logic [N-1:0] held_c, held_t;
  longint abs_c = 0;
  longint abs_t = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Column model built from the recoding rules
  function automatic logic [N-1:0] model(input logic [N-1:0] a, input logic [N-1:0] b,
                                         input bit comp, output int em);
    longint sum = 0;
    longint sa = longint'($signed(a));
    em = 0;
    for (int i = 0; i < H; i++) begin
      int t2 = int'(b[2*i+1]);
      int t1 = int'(b[2*i]);
      int t0 = (i == 0) ? 0 : int'(b[2*i-1]);
      longint d = longint'(t1 + t0 - 2 * t2);
      longint ng = longint'(t2 & ~(t1 & t0) & 1);
      longint rv = (d * sa - ng) & ((64'sd1 <<< (N + 1)) - 1);
      for (int j = 0; j <= N; j++) begin
        longint bv = (rv >>> j) & 1;
        int col = 2 * i + j;
        if (j == N) bv = bv ^ 1;
        if (col >= N) sum += bv <<< col;
        if (col == N - 1) em += int'(bv);
      end
    end
    sum -= (64'sd1 <<< N) * (((64'sd1 <<< N) - 1) / 3);
    if (comp) sum += longint'(em + ((em == H) ? 1 : 0) - 1) <<< N;
    return N'(sum >>> N);
  endfunction

  task automatic step(input bit v, input logic [N-1:0] a, input logic [N-1:0] b, input bit r);
    @(negedge clk);
    // R8: a pair taken on the last edge is now presented
    if (pushed_last) check(vld_c == 1'b1, "R8 valid after accept", vld_c, 1);
    // R9: a stalled result did not change
    if (stalled_last) begin
      check(vld_c == 1'b1, "R9 valid held", vld_c, 1);
      check(prod_c == held_c && prod_t == held_t, "R9 result held", prod_c, held_c);
    end
    in_valid = v; in_a = a; in_b = b; out_ready = r;
    #1;
    stalled_last = 1'b0;
    if (vld_c && !r) begin
      check(rdy_c == 1'b0 && rdy_t == 1'b0, "R9 ready low in stall", rdy_c, 0);
      stalled_last = 1'b1;
      held_c = prod_c; held_t = prod_t;
    end
    if (r) check(rdy_c == 1'b1, "R10 ready in free flow", rdy_c, 1);
    if (vld_c && r) begin
      if (qa.size() == 0) begin
        check(1'b0, "R8 unexpected result", prod_c, -1);
      end else begin
        logic [N-1:0] ea = qa.pop_front();
        logic [N-1:0] eb = qb.pop_front();
        int em, emt;
        logic [N-1:0] xc = model(ea, eb, 1'b1, em);
        logic [N-1:0] xt = model(ea, eb, 1'b0, emt);
        longint exact = longint'($signed(ea)) * longint'($signed(eb));
        longint ec = exact - (longint'($signed(prod_c)) <<< N);
        longint et = exact - (longint'($signed(prod_t)) <<< N);
        if (em == H) begin
          full_hits++;
          check(prod_c == xc, "R5 full column estimate", prod_c, xc);
        end else begin
          check(prod_c == xc, "R4 compensated result", prod_c, xc);
        end
        check(prod_t == xt, "R2 R3 truncated result", prod_t, xt);
        check(et >= 0 && et < (longint'(H + 1) <<< N), "R3 truncation error range", et, 0);
        if (eb == '0) begin
          check(prod_c == {N{1'b1}}, "R6 zero multiplier compensated", prod_c, {N{1'b1}});
          check(prod_t == '0, "R6 zero multiplier truncated", prod_t, 0);
        end
        if (stats_on) begin
          abs_c += (ec < 0) ? -ec : ec;
          abs_t += (et < 0) ? -et : et;
        end
      end
    end
    pushed_last = 1'b0;
    if (v && rdy_c) begin
      qa.push_back(a); qb.push_back(b);
      pushed_last = 1'b1;
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // R1: reset state
    repeat (4) begin
      @(negedge clk);
      check(vld_c == 1'b0 && vld_t == 1'b0, "R1 valid low in reset", vld_c, 0);
      check(rdy_c == 1'b1, "R1 ready high in reset", rdy_c, 1);
    end
    rst = 1'b0;
    @(negedge clk);
    check(vld_c == 1'b0, "R1 valid low after reset", vld_c, 0);

    // directed corners: extremes, zero multiplier, one, minus one
    step(1, 8'h80, 8'h80, 1);
    step(1, 8'h7f, 8'h7f, 1);
    step(1, 8'h80, 8'h7f, 1);
    step(1, 8'h5a, 8'h00, 1);
    step(1, 8'h80, 8'h00, 1);
    step(1, 8'hff, 8'hff, 1);
    step(1, 8'h01, 8'h80, 1);
    step(1, 8'h7f, 8'hff, 0);
    step(0, 8'h00, 8'h00, 0);
    step(0, 8'h00, 8'h00, 1);

    // random operands with random valid and back-pressure
    for (int k = 0; k < 3000; k++) begin
      step(($urandom % 4) != 0, N'($urandom), N'($urandom), ($urandom % 10) < 7);
    end
    for (int k = 0; k < 4; k++) step(0, '0, '0, 1);

    // exhaustive sweep at full rate for the error statistics
    stats_on = 1'b1;
    for (int x = 0; x < (1 << N); x++) begin
      for (int y = 0; y < (1 << N); y++) begin
        step(1, N'(x), N'(y), 1);
      end
    end
    for (int k = 0; k < 4; k++) step(0, '0, '0, 1);
    stats_on = 1'b0;

    check(qa.size() == 0, "R8 all results delivered", qa.size(), 0);
    check(full_hits > 0, "R5 full column case reached", full_hits, 1);
    check(abs_c < abs_t, "R7 compensated mean error smaller", abs_c, abs_t);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule